// File: doc/BRIEF.md
# UART Interrupt Source Identifier

This block decides which interrupt a 16550-style UART reports while its FIFOs are enabled, and drives the interrupt line. It watches the receive FIFO fill level, the receiver's character and error events, the transmitter's holding-register events and the CPU's read strobes. It keeps four sources: line status, received data at the trigger level, receive inactivity timeout and transmit holding empty. The most urgent enabled source is encoded into the identification byte. The FIFO storage, the character-time generator and the modem-status sources live elsewhere. The `char_tick` input pulses once per character time.

Two enumerated machines carry the behaviour. The idle timer has three states. `TMR_EMPTY` means the receive FIFO holds nothing. `TMR_COUNT` means bytes are held and character times are being counted. `TMR_FIRED` means the timeout is pending. Its transitions are:
- Arm: EMPTY to COUNT when the count becomes nonzero.
- Restart: any state to COUNT with the tick count at zero, on a push or a data read.
- Expire: COUNT to FIRED on the fourth tick.
- Drain: any state to EMPTY when the count is zero or FIFO mode is off.

The source selector is a second enumeration: `SRC_LINE`, `SRC_RDA`, `SRC_TIMEOUT`, `SRC_THRE` and `SRC_NONE`. It is re-evaluated every cycle in that priority order. Pending flags are registered and the identification byte is combinational from them, so an event captured on a clock edge is visible right after that edge.

Top module: `uart_irq_id`

## Requirements
- R1: `iir[7:6]` reads 2'b11 while `fifo_en` is 1 and 2'b00 while it is 0; `iir[5:4]` always read 0.
- R2: With no enabled source pending, `iir[3:0]` is 4'b0001 and `irq` is 0; this holds straight out of reset.
- R3: In FIFO mode `trig_sel` selects the receive trigger level: 0 gives 1 byte, 1 gives 4, 2 gives 8 and 3 gives 14. With `fifo_en` 0 the level is 1.
- R4: The received-data source (code 4'b0100) is pending exactly while `rx_count` is at or above the trigger level. It follows `rx_count` in the same cycle, so it drops as soon as the count falls below the level.
- R5: In FIFO mode, with `rx_count` nonzero and no push or data read, the timeout source (code 4'b1100) becomes pending on the clock edge that samples the fourth `char_tick` pulse. After three pulses it is not pending.
- R6: A `rx_push` or `rd_data` pulse clears a pending timeout and restarts the tick count from zero. This holds even when the pulse coincides with the tick that would have expired it.
- R7: The line-status source (code 4'b0110) is set by an `rx_overrun` pulse or by a rising edge of `rx_head_err`. It is cleared by `rd_status`. A set in the same cycle as `rd_status` wins.
- R8: The transmit-empty source (code 4'b0010) is set by a `thr_empty` pulse. It is cleared by `thr_write`, or by `rd_iir` only while 4'b0010 is the code being reported. A set wins over a same-cycle clear.
- R9: Priority from highest: line status, received data, timeout, transmit empty.
- R10: `int_en[0]` enables received data and timeout, `int_en[1]` enables transmit empty and `int_en[2]` enables line status. A disabled source is not reported but stays latched, and it appears once its enable is set.
- R11: `irq` is 1 exactly when `iir[0]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFO mode enabled |
| trig_sel | input | 2 | Receive trigger level select |
| rx_count | input | CNT_W (5) | Bytes currently held in the receive FIFO |
| rx_push | input | 1 | Pulse: a character entered the receive FIFO |
| rx_head_err | input | 1 | Level: the character at the FIFO head carries an error |
| rx_overrun | input | 1 | Pulse: a receive overrun occurred |
| thr_empty | input | 1 | Pulse: transmit holding storage became empty |
| thr_write | input | 1 | Pulse: CPU wrote the transmit holding register |
| int_en | input | 3 | Interrupt enables (rx data/timeout, tx empty, line status) |
| char_tick | input | 1 | Pulse once per character time |
| rd_data | input | 1 | Pulse: CPU read of the receive data register |
| rd_status | input | 1 | Pulse: CPU read of the line status register |
| rd_iir | input | 1 | Pulse: CPU read of the identification register |
| iir | output | 8 | Interrupt identification byte |
| irq | output | 1 | Interrupt request |

## Verification
Two collisions are provoked on purpose. In the first, a data read lands in the same cycle as the fourth character tick; the identification must stay at no-interrupt, and the timeout must need four fresh ticks afterwards. In the second, a status read coincides with a new overrun pulse; the line-status code must still be reported on the following cycle. Both are judged by sampling `iir` and `irq` at the falling edge after the colliding edge.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [1:0] {
        TMR_EMPTY = 2'd0,
        TMR_COUNT = 2'd1,
        TMR_FIRED = 2'd2
    } tmr_state_t;

    typedef enum logic [2:0] {
        SRC_NONE    = 3'd0,
        SRC_THRE    = 3'd1,
        SRC_TIMEOUT = 3'd2,
        SRC_RDA     = 3'd3,
        SRC_LINE    = 3'd4
    } irq_src_t;

    localparam logic [3:0] ID_NONE = 4'b0001;
    localparam logic [3:0] ID_THRE = 4'b0010;
    localparam logic [3:0] ID_RDA  = 4'b0100;
    localparam logic [3:0] ID_TMO  = 4'b1100;
    localparam logic [3:0] ID_LINE = 4'b0110;

    function automatic logic [3:0] src_code(input irq_src_t s);
        logic [3:0] c;
        unique case (s)
            SRC_LINE:    c = ID_LINE;
            SRC_RDA:     c = ID_RDA;
            SRC_TIMEOUT: c = ID_TMO;
            SRC_THRE:    c = ID_THRE;
            default:     c = ID_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/irq_trig_level.sv
module irq_trig_level #(
    parameter int CNT_W = 5,
    parameter int LVL0  = 1,
    parameter int LVL1  = 4,
    parameter int LVL2  = 8,
    parameter int LVL3  = 14
) (
    input  logic             fifo_en,
    input  logic [1:0]       trig_sel,
    input  logic [CNT_W-1:0] rx_count,
    output logic             rda_hit
);
    localparam int NLVL = 4;

    logic [CNT_W-1:0] lvl_tab [NLVL];
    logic [CNT_W-1:0] level;

    // R3: one table entry per trigger-select code
    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
        localparam int V = (g == 0) ? LVL0 : (g == 1) ? LVL1 : (g == 2) ? LVL2 : LVL3;
        assign lvl_tab[g] = CNT_W'(V);
    end

    always_comb begin
        level   = fifo_en ? lvl_tab[trig_sel] : CNT_W'(1);
        rda_hit = (rx_count >= level);
    end

endmodule

// File: rtl/irq_idle_timer.sv
module irq_idle_timer
    import uart_irq_pkg::*;
#(
    parameter int CNT_W    = 5,
    parameter int TO_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_push,
    input  logic             rd_data,
    input  logic             char_tick,
    output logic             tmo_pend
);
    localparam int TW = (TO_TICKS > 1) ? $clog2(TO_TICKS) : 1;
    localparam logic [TW-1:0] LAST = TW'(TO_TICKS - 1);

    tmr_state_t      st, st_n;
    logic [TW-1:0]   cnt, cnt_n;
    logic            held, restart;

    assign held    = (rx_count != '0);
    assign restart = rx_push | rd_data;

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        if (!enable || !held) begin
            st_n  = TMR_EMPTY;            // drain
            cnt_n = '0;
        end else if (restart) begin
            st_n  = TMR_COUNT;            // restart
            cnt_n = '0;
        end else begin
            unique case (st)
                TMR_EMPTY: begin          // arm
                    st_n  = TMR_COUNT;
                    cnt_n = '0;
                end
                TMR_COUNT: begin
                    if (char_tick) begin
                        if (cnt == LAST) begin
                            st_n  = TMR_FIRED;   // expire
                            cnt_n = '0;
                        end else begin
                            cnt_n = cnt + TW'(1);
                        end
                    end
                end
                TMR_FIRED: begin
                    st_n = TMR_FIRED;
                end
                default: begin
                    st_n  = TMR_EMPTY;
                    cnt_n = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= TMR_EMPTY;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    always_comb begin
        tmo_pend = (st == TMR_FIRED);
    end

    // R5: the timeout only appears on an edge that sampled a tick
    p_tmo_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_pend) |-> $past(char_tick));

    // R6: a push or a data read leaves no timeout pending
    p_restart_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push || rd_data) |=> !tmo_pend);

endmodule

// File: rtl/irq_event_latch.sv
module irq_event_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_head_err,
    input  logic rx_overrun,
    input  logic rd_status,
    input  logic thr_empty,
    input  logic thr_write,
    input  logic thre_ack,
    output logic ls_pend,
    output logic thre_pend
);
    logic head_q;
    logic ls_set, thre_clr;

    assign ls_set   = rx_overrun | (rx_head_err & ~head_q);
    assign thre_clr = thr_write | thre_ack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q    <= 1'b0;
            ls_pend   <= 1'b0;
            thre_pend <= 1'b0;
        end else begin
            head_q <= rx_head_err;
            if (ls_set)          ls_pend <= 1'b1;
            else if (rd_status)  ls_pend <= 1'b0;
            if (thr_empty)       thre_pend <= 1'b1;
            else if (thre_clr)   thre_pend <= 1'b0;
        end
    end

    // R7: an overrun always leaves line status pending, read or not
    p_overrun_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |=> ls_pend);

    // R7: a status read with no new event clears line status
    p_status_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !rx_overrun && !rx_head_err) |=> !ls_pend);

    // R8: transmit-empty event always latches
    p_thre_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        thr_empty |=> thre_pend);

endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
    import uart_irq_pkg::*;
#(
    parameter int CNT_W    = 5,
    parameter int TO_TICKS = 4,
    parameter int LVL0     = 1,
    parameter int LVL1     = 4,
    parameter int LVL2     = 8,
    parameter int LVL3     = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [1:0]       trig_sel,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_push,
    input  logic             rx_head_err,
    input  logic             rx_overrun,
    input  logic             thr_empty,
    input  logic             thr_write,
    input  logic [2:0]       int_en,
    input  logic             char_tick,
    input  logic             rd_data,
    input  logic             rd_status,
    input  logic             rd_iir,
    output logic [7:0]       iir,
    output logic             irq
);
    logic     rda_hit, tmo_pend, ls_pend, thre_pend, thre_ack;
    irq_src_t src;

    irq_trig_level #(
        .CNT_W(CNT_W), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
    ) u_lvl (
        .fifo_en  (fifo_en),
        .trig_sel (trig_sel),
        .rx_count (rx_count),
        .rda_hit  (rda_hit)
    );

    irq_idle_timer #(.CNT_W(CNT_W), .TO_TICKS(TO_TICKS)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (fifo_en),
        .rx_count  (rx_count),
        .rx_push   (rx_push),
        .rd_data   (rd_data),
        .char_tick (char_tick),
        .tmo_pend  (tmo_pend)
    );

    irq_event_latch u_evt (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_head_err (rx_head_err),
        .rx_overrun  (rx_overrun),
        .rd_status   (rd_status),
        .thr_empty   (thr_empty),
        .thr_write   (thr_write),
        .thre_ack    (thre_ack),
        .ls_pend     (ls_pend),
        .thre_pend   (thre_pend)
    );

    // R9: fixed priority selection among enabled sources
    always_comb begin
        if (ls_pend && int_en[2])           src = SRC_LINE;
        else if (rda_hit && int_en[0])      src = SRC_RDA;
        else if (tmo_pend && int_en[0])     src = SRC_TIMEOUT;
        else if (thre_pend && int_en[1])    src = SRC_THRE;
        else                                src = SRC_NONE;
    end

    assign thre_ack = rd_iir && (src == SRC_THRE);

    always_comb begin
        iir = {{2{fifo_en}}, 2'b00, src_code(src)};
        irq = (src != SRC_NONE);
    end

    // R11: request line agrees with the no-pending bit
    p_irq_vs_id_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq == !iir[0]);

    // R1: mode bits follow FIFO enable
    p_mode_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
        iir[7:4] == {fifo_en, fifo_en, 2'b00});

    // R8: reading the id while transmit-empty is reported clears it
    p_thre_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_iir && iir[3:0] == ID_THRE && !thr_empty) |=> iir[3:0] != ID_THRE);

endmodule

// File: tb/tb_uart_irq_id.sv
module tb_uart_irq_id;
    localparam int CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fifo_en = 1'b0;
    logic [1:0]       trig_sel = 2'd0;
    logic [CNT_W-1:0] rx_count = '0;
    logic             rx_push = 1'b0, rx_head_err = 1'b0, rx_overrun = 1'b0;
    logic             thr_empty = 1'b0, thr_write = 1'b0;
    logic [2:0]       int_en = 3'd0;
    logic             char_tick = 1'b0, rd_data = 1'b0, rd_status = 1'b0, rd_iir = 1'b0;
    logic [7:0]       iir;
    logic             irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uart_irq_id #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
        .rx_count(rx_count), .rx_push(rx_push), .rx_head_err(rx_head_err),
        .rx_overrun(rx_overrun), .thr_empty(thr_empty), .thr_write(thr_write),
        .int_en(int_en), .char_tick(char_tick), .rd_data(rd_data),
        .rd_status(rd_status), .rd_iir(rd_iir), .iir(iir), .irq(irq)
    );

    // vector: {fifo_en, trig_sel, rx_count, int_en, expected low nibble}
    localparam int NV = 12;
    localparam logic [14:0] VEC [NV] = '{
        {1'b1, 2'd0, 5'd0,  3'd7, 4'h1},   // R2
        {1'b1, 2'd0, 5'd1,  3'd1, 4'h4},   // R3 R4 level 1
        {1'b1, 2'd1, 5'd3,  3'd1, 4'h1},   // R4 below 4
        {1'b1, 2'd1, 5'd4,  3'd1, 4'h4},
        {1'b1, 2'd2, 5'd7,  3'd1, 4'h1},
        {1'b1, 2'd2, 5'd8,  3'd1, 4'h4},
        {1'b1, 2'd3, 5'd13, 3'd1, 4'h1},
        {1'b1, 2'd3, 5'd14, 3'd1, 4'h4},
        {1'b1, 2'd3, 5'd16, 3'd1, 4'h4},
        {1'b1, 2'd3, 5'd14, 3'd6, 4'h1},   // R10 rx disabled
        {1'b0, 2'd3, 5'd1,  3'd1, 4'h4},   // R1 R3 non-FIFO level 1
        {1'b0, 2'd0, 5'd0,  3'd1, 4'h1}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FIFO-ID FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic chk_id(input string req, input logic [7:0] exp);
        #1;
        chk(req, iir, exp);
        chk({req, " irq"}, {7'd0, irq}, {7'd0, ~exp[0]});
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) char_tick = 1'b1;
            @(negedge clk) char_tick = 1'b0;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_bad++;
        $display("FIFO-ID FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        // reset state R2 R1
        #5;
        chk_id("R2 reset", 8'h01);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_id("R2 after reset", 8'h01);

        // table walk
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            fifo_en  = VEC[v][14];
            trig_sel = VEC[v][13:12];
            rx_count = VEC[v][11:7];
            int_en   = VEC[v][6:4];
            chk_id($sformatf("R1 R3 R4 R10 vec%0d", v),
                   {{2{VEC[v][14]}}, 2'b00, VEC[v][3:0]});
        end

        // timeout R5 R6
        @(negedge clk);
        fifo_en = 1'b1; trig_sel = 2'd3; int_en = 3'd1; rx_count = 5'd2;
        @(negedge clk);
        ticks(3);
        chk_id("R5 three ticks", 8'hC1);
        ticks(1);
        chk_id("R5 fourth tick", 8'hCC);
        @(negedge clk) rd_data = 1'b1;
        @(negedge clk) rd_data = 1'b0;
        chk_id("R6 data read clears", 8'hC1);
        ticks(3);
        @(negedge clk) begin char_tick = 1'b1; rd_data = 1'b1; end
        @(negedge clk) begin char_tick = 1'b0; rd_data = 1'b0; end
        chk_id("R6 read with fourth tick", 8'hC1);
        ticks(3);
        chk_id("R6 restarted count", 8'hC1);
        ticks(1);
        chk_id("R6 expiry after restart", 8'hCC);
        @(negedge clk) rx_push = 1'b1;
        @(negedge clk) rx_push = 1'b0;
        chk_id("R6 push clears", 8'hC1);
        rx_count = 5'd0;

        // line status R7
        int_en = 3'd7;
        @(negedge clk) rx_overrun = 1'b1;
        @(negedge clk) rx_overrun = 1'b0;
        chk_id("R7 overrun", 8'hC6);
        @(negedge clk) rd_status = 1'b1;
        @(negedge clk) rd_status = 1'b0;
        chk_id("R7 status read", 8'hC1);
        @(negedge clk) begin rd_status = 1'b1; rx_overrun = 1'b1; end
        @(negedge clk) begin rd_status = 1'b0; rx_overrun = 1'b0; end
        chk_id("R7 set beats read", 8'hC6);
        @(negedge clk) rd_status = 1'b1;
        @(negedge clk) rd_status = 1'b0;
        @(negedge clk) rx_head_err = 1'b1;
        @(negedge clk);
        chk_id("R7 head error rise", 8'hC6);
        @(negedge clk) rd_status = 1'b1;
        @(negedge clk) rd_status = 1'b0;
        repeat (2) @(negedge clk);
        chk_id("R7 held error no reset", 8'hC1);
        rx_head_err = 1'b0;
        @(negedge clk) rx_head_err = 1'b1;
        @(negedge clk);
        chk_id("R7 second rise", 8'hC6);
        rx_head_err = 1'b0;
        @(negedge clk) rd_status = 1'b1;
        @(negedge clk) rd_status = 1'b0;

        // priority R9 and tx empty R8
        rx_count = 5'd14;
        chk_id("R9 rda alone", 8'hC4);
        @(negedge clk) begin rx_overrun = 1'b1; thr_empty = 1'b1; end
        @(negedge clk) begin rx_overrun = 1'b0; thr_empty = 1'b0; end
        chk_id("R9 line over rda", 8'hC6);
        @(negedge clk) rd_status = 1'b1;
        @(negedge clk) rd_status = 1'b0;
        chk_id("R9 rda over thre", 8'hC4);
        rx_count = 5'd0;
        chk_id("R8 thre reported", 8'hC2);
        @(negedge clk) rd_iir = 1'b1;
        @(negedge clk) rd_iir = 1'b0;
        chk_id("R8 id read clears", 8'hC1);
        @(negedge clk) thr_empty = 1'b1;
        @(negedge clk) thr_empty = 1'b0;
        @(negedge clk) thr_write = 1'b1;
        @(negedge clk) thr_write = 1'b0;
        chk_id("R8 write clears", 8'hC1);
        @(negedge clk) begin thr_empty = 1'b1; rx_overrun = 1'b1; end
        @(negedge clk) begin thr_empty = 1'b0; rx_overrun = 1'b0; rd_iir = 1'b1; end
        @(negedge clk) begin rd_iir = 1'b0; rd_status = 1'b1; end
        @(negedge clk) rd_status = 1'b0;
        chk_id("R8 id read while other source keeps thre", 8'hC2);
        @(negedge clk) thr_write = 1'b1;
        @(negedge clk) thr_write = 1'b0;

        // enable masking R10
        int_en = 3'd0;
        @(negedge clk) rx_overrun = 1'b1;
        @(negedge clk) rx_overrun = 1'b0;
        chk_id("R10 masked line status", 8'hC1);
        int_en = 3'b100;
        chk_id("R10 latched source appears", 8'hC6);
        @(negedge clk) rd_status = 1'b1;
        @(negedge clk) rd_status = 1'b0;
        chk_id("R10 cleared", 8'hC1);

        finish_run();
    end

endmodule